// File: doc/BRIEF.md
# Multichannel AAL1 Cell Transmit Scheduler

This block serves a group of constant-bit-rate channels that each fill a payload area of 47 bytes in a shared memory. A producer raises one ready flag per channel when that channel's payload is complete. The scheduler looks for ready channels in rotating order. When it finds one, it sends a 48-byte AAL1 cell on a byte-wide valid/ready stream. The cell starts with a one-byte header that carries a timing-indication bit, the channel's 3-bit sequence count and the protection bits computed from them. The header is followed by the channel's payload bytes, which are read one by one from the memory.

After the last byte of a cell is accepted, the block pulses a clear strobe that names the channel, so the producer can drop that channel's flag. It also advances the sequence count that it keeps for that channel. While no channel is ready the scan pointer stays where it is, so service resumes right after the channel served last. The memory read port is combinational: the data for the presented channel and byte index must come back in the same cycle.

Top module: `aal1_tx_sched`

## Requirements
- R1: A cell is exactly 1 + PAYLOAD_BYTES (48) accepted bytes. After the header come payload bytes 0 to 46 of the served channel, in that order, read through mem_ch_o/mem_idx_o.
- R2: Header bit 7 is the indication bit. Bits 6:4 are the sequence count, MSB first. Bits 3:1 are the CRC remainder of those four bits times x^3 modulo x^3+x+1. Bit 0 makes the parity of the whole byte even.
- R3: The indication bit is taken from csi_i of the chosen channel in the cycle the channel is chosen. Changes to csi_i after that do not alter the header of that cell.
- R4: The channel served is the first channel whose flag is set, searching upward from the channel after the one served last and wrapping from N_CH-1 to 0. Channels without a flag are skipped.
- R5: Each channel has its own sequence count. It rises by one after each completed cell of that channel and wraps from 7 to 0.
- R6: One cycle after the last byte of a cell is accepted, flag_clr_o is high for exactly one cycle and flag_clr_ch_o gives the served channel. In that cycle the served channel is not chosen again.
- R7: While cell_valid_o is high and cell_ready_i is low, cell_valid_o, cell_data_o and cell_sof_o hold their values and no byte is lost.
- R8: After reset, cell_valid_o and flag_clr_o are low, all sequence counts are 0 and the search starts at channel 0.
- R9: cell_sof_o is high on the header byte and only on the header byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_flag_i | input | N_CH | Per-channel payload-ready flags |
| csi_i | input | N_CH | Per-channel indication bit for the header |
| flag_clr_o | output | 1 | One-cycle strobe: the served channel's flag may be cleared |
| flag_clr_ch_o | output | CH_W | Channel that flag_clr_o refers to |
| mem_ch_o | output | CH_W | Payload memory read: channel |
| mem_idx_o | output | IDX_W | Payload memory read: byte index 0..46 |
| mem_data_i | input | 8 | Payload memory read data, same cycle |
| cell_data_o | output | 8 | Cell byte stream |
| cell_valid_o | output | 1 | Byte on cell_data_o is valid |
| cell_sof_o | output | 1 | Byte is the cell header |
| cell_ready_i | input | 1 | Sink accepts the byte |

## Verification
The properties rely on three things from the environment. Payload memory contents stay fixed while a cell is in flight. A channel's flag stays set from the moment the channel is chosen until its clear strobe. The producer clears a flag in the strobe cycle. The bench loads the memory once and sets new flags only while the scheduler is idle with every flag low. It clears a flag only when it sees the strobe. A random ready pattern and a forced stall put pressure on the hold behaviour without touching these conditions.

// File: rtl/aal1_tx_pkg.sv
package aal1_tx_pkg;

  typedef enum logic {ST_SCAN, ST_SEND} tx_state_e;

  // remainder of {csi,sc}*x^3 mod x^3+x+1, message MSB first
  function automatic logic [2:0] crc3(input logic [3:0] msg);
    logic [2:0] r;
    logic       fb;
    r = 3'b000;
    for (int i = 3; i >= 0; i--) begin
      fb = r[2] ^ msg[i];
      r  = {r[1:0], 1'b0} ^ (fb ? 3'b011 : 3'b000);
    end
    return r;
  endfunction

  function automatic logic [7:0] aal1_hdr(input logic csi, input logic [2:0] sc);
    logic [6:0] h;
    h = {csi, sc, crc3({csi, sc})};
    return {h, ^h};
  endfunction

endpackage

// File: rtl/aal1_rr_pick.sv
module aal1_rr_pick #(
  parameter int unsigned N_CH = 8,
  parameter int unsigned CH_W = 3
) (
  input  logic [N_CH-1:0] req_i,
  input  logic [CH_W-1:0] base_i,
  output logic            found_o,
  output logic [CH_W-1:0] sel_o
);
  // lowest offset from base wins: iterate downward so it is assigned last
  always_comb begin
    found_o = 1'b0;
    sel_o   = '0;
    for (int k = N_CH - 1; k >= 0; k--) begin
      int unsigned c;
      c = (int'(base_i) + k) % N_CH;
      if (req_i[c]) begin
        found_o = 1'b1;
        sel_o   = CH_W'(c);
      end
    end
  end
endmodule

// File: rtl/aal1_sc_store.sv
module aal1_sc_store #(
  parameter int unsigned N_CH = 8,
  parameter int unsigned CH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CH_W-1:0] rd_ch_i,
  output logic [2:0]      rd_sc_o,
  input  logic            inc_i,
  input  logic [CH_W-1:0] inc_ch_i
);
  logic [2:0] sc_q [N_CH];

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  sc_q[g] <= 3'd0;
      else if (inc_i && (inc_ch_i == CH_W'(g)))     sc_q[g] <= sc_q[g] + 3'd1;
    end
  end

  assign rd_sc_o = sc_q[rd_ch_i];
endmodule

// File: rtl/aal1_hdr_build.sv
module aal1_hdr_build
  import aal1_tx_pkg::*;
(
  input  logic       csi_i,
  input  logic [2:0] sc_i,
  output logic [7:0] hdr_o
);
  assign hdr_o = aal1_hdr(csi_i, sc_i);
endmodule

// File: rtl/aal1_tx_sched.sv
module aal1_tx_sched
  import aal1_tx_pkg::*;
#(
  parameter int unsigned N_CH          = 8,
  parameter int unsigned PAYLOAD_BYTES = 47,
  localparam int unsigned CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int unsigned IDX_W = $clog2(PAYLOAD_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CH-1:0]  ready_flag_i,
  input  logic [N_CH-1:0]  csi_i,
  output logic             flag_clr_o,
  output logic [CH_W-1:0]  flag_clr_ch_o,
  output logic [CH_W-1:0]  mem_ch_o,
  output logic [IDX_W-1:0] mem_idx_o,
  input  logic [7:0]       mem_data_i,
  output logic [7:0]       cell_data_o,
  output logic             cell_valid_o,
  output logic             cell_sof_o,
  input  logic             cell_ready_i
);
  localparam int unsigned CNT_W = $clog2(PAYLOAD_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PAYLOAD_BYTES);
  localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(N_CH - 1);

  tx_state_e        state_q;
  logic [CH_W-1:0]  cur_ch_q, ptr_q, clr_ch_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       hdr_q;
  logic             clr_q;

  logic [N_CH-1:0]  req_mask;
  logic             found;
  logic [CH_W-1:0]  sel;
  logic [2:0]       sc_rd;
  logic [7:0]       hdr_new;
  logic             accept, last_byte;

  // hide the channel whose flag is being dropped this cycle
  always_comb begin
    req_mask = ready_flag_i;
    if (clr_q) req_mask[clr_ch_q] = 1'b0;
  end

  aal1_rr_pick #(.N_CH(N_CH), .CH_W(CH_W)) u_pick (
    .req_i   (req_mask),
    .base_i  (ptr_q),
    .found_o (found),
    .sel_o   (sel)
  );

  aal1_sc_store #(.N_CH(N_CH), .CH_W(CH_W)) u_sc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_ch_i  (sel),
    .rd_sc_o  (sc_rd),
    .inc_i    (accept && last_byte),
    .inc_ch_i (cur_ch_q)
  );

  aal1_hdr_build u_hdr (
    .csi_i (csi_i[sel]),
    .sc_i  (sc_rd),
    .hdr_o (hdr_new)
  );

  assign accept    = (state_q == ST_SEND) && cell_ready_i;
  assign last_byte = (cnt_q == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_SCAN;
      cur_ch_q <= '0;
      ptr_q    <= '0;
      cnt_q    <= '0;
      hdr_q    <= '0;
      clr_q    <= 1'b0;
      clr_ch_q <= '0;
    end else begin
      clr_q <= 1'b0;
      unique case (state_q)
        ST_SCAN: begin
          if (found) begin
            state_q  <= ST_SEND;
            cur_ch_q <= sel;
            hdr_q    <= hdr_new;
            cnt_q    <= '0;
          end
        end
        ST_SEND: begin
          if (accept) begin
            if (last_byte) begin
              state_q  <= ST_SCAN;
              ptr_q    <= (cur_ch_q == LAST_CH) ? '0 : cur_ch_q + 1'b1;
              clr_q    <= 1'b1;
              clr_ch_q <= cur_ch_q;
              cnt_q    <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_SCAN;
      endcase
    end
  end

  assign cell_valid_o  = (state_q == ST_SEND);
  assign cell_sof_o    = cell_valid_o && (cnt_q == '0);
  assign cell_data_o   = (cnt_q == '0) ? hdr_q : mem_data_i;
  assign mem_ch_o      = cur_ch_q;
  assign mem_idx_o     = (cnt_q == '0) ? '0 : IDX_W'(cnt_q - 1'b1);
  assign flag_clr_o    = clr_q;
  assign flag_clr_ch_o = clr_ch_q;

endmodule

// File: rtl/aal1_tx_sched_chk.sv
module aal1_tx_sched_chk #(
  parameter int unsigned N_CH          = 8,
  parameter int unsigned PAYLOAD_BYTES = 47,
  localparam int unsigned CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int unsigned IDX_W = $clog2(PAYLOAD_BYTES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_CH-1:0]  ready_flag_i,
  input logic [N_CH-1:0]  csi_i,
  input logic             flag_clr_o,
  input logic [CH_W-1:0]  flag_clr_ch_o,
  input logic [CH_W-1:0]  mem_ch_o,
  input logic [IDX_W-1:0] mem_idx_o,
  input logic [7:0]       mem_data_i,
  input logic [7:0]       cell_data_o,
  input logic             cell_valid_o,
  input logic             cell_sof_o,
  input logic             cell_ready_i
);
  localparam int unsigned CNT_W = $clog2(PAYLOAD_BYTES + 1);

  logic [CNT_W-1:0] acc_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_cnt <= '0;
    else if (cell_valid_o && cell_ready_i)
      acc_cnt <= (acc_cnt == CNT_W'(PAYLOAD_BYTES)) ? '0 : acc_cnt + 1'b1;
  end

  p_sof_on_header_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_valid_o |-> (cell_sof_o == (acc_cnt == '0)));

  p_hdr_parity_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_valid_o && cell_sof_o) |-> (^cell_data_o == 1'b0));

  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_valid_o && !cell_ready_i) |=>
      (cell_valid_o && $stable(cell_data_o) && $stable(cell_sof_o)));

  p_clr_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_o |=> !flag_clr_o);

  p_clr_after_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_o |-> ($past(cell_valid_o && cell_ready_i) && acc_cnt == '0
                    && $past(mem_ch_o) == flag_clr_ch_o));

  p_ch_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_valid_o && !cell_sof_o) |-> $stable(mem_ch_o));

  p_served_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_valid_o && cell_sof_o) |-> ready_flag_i[mem_ch_o]);

  p_idx_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_valid_o |-> (int'(mem_idx_o) < PAYLOAD_BYTES));

endmodule

bind aal1_tx_sched aal1_tx_sched_chk #(.N_CH(N_CH), .PAYLOAD_BYTES(PAYLOAD_BYTES)) u_chk (.*);

// File: tb/aal1_tx_sched_tb.sv
module aal1_tx_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH = 8;
  localparam int PB   = 47;
  localparam int CH_W = 3;
  localparam int IDX_W = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N_CH-1:0] flags = '0;
  logic [N_CH-1:0] csi_b = '0;
  logic cell_ready = 1'b0;
  logic flag_clr;
  logic [CH_W-1:0] flag_clr_ch, mem_ch;
  logic [IDX_W-1:0] mem_idx;
  logic [7:0] mem_data, cell_data;
  logic cell_valid, cell_sof;

  logic [7:0] mem [N_CH][PB];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb mem_data = (int'(mem_idx) < PB) ? mem[mem_ch][mem_idx] : 8'h00;

  aal1_tx_sched #(.N_CH(N_CH), .PAYLOAD_BYTES(PB)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ready_flag_i(flags), .csi_i(csi_b),
    .flag_clr_o(flag_clr), .flag_clr_ch_o(flag_clr_ch),
    .mem_ch_o(mem_ch), .mem_idx_o(mem_idx), .mem_data_i(mem_data),
    .cell_data_o(cell_data), .cell_valid_o(cell_valid), .cell_sof_o(cell_sof),
    .cell_ready_i(cell_ready)
  );

  int total = 0, bad = 0;
  bit done = 0, force_stall = 0;
  int exp_ptr = 0, cnt = 0, cur_ch = 0, clr_ch = 0;
  bit open_cell = 0, clr_pend = 0, prev_stall = 0;
  logic [2:0] exp_sc [N_CH];
  logic [7:0] cur_hdr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // header by polynomial long division, independent of the RTL form
  function automatic logic [7:0] hdr_model(input logic csi, input logic [2:0] sc);
    logic [6:0] r;
    logic [6:0] h;
    r = {csi, sc, 3'b000};
    for (int b = 6; b >= 3; b--)
      if (r[b]) r[b -: 4] = r[b -: 4] ^ 4'b1011;
    h = {csi, sc, r[2:0]};
    return {h, ^h};
  endfunction

  function automatic int pick_model();
    for (int k = 0; k < N_CH; k++) begin
      int c;
      c = (exp_ptr + k) % N_CH;
      if (flags[c]) return c;
    end
    return -1;
  endfunction

  // monitor and flag owner for clears
  initial begin
    for (int c = 0; c < N_CH; c++) exp_sc[c] = 3'd0;
    @(posedge rst_ni);
    forever begin
      @(negedge clk);
      cell_ready = force_stall ? 1'b0 : ($urandom_range(0, 3) != 0);
      #1;
      if (clr_pend) begin
        chk(flag_clr && int'(flag_clr_ch) == clr_ch, "R6 clear strobe", int'(flag_clr_ch), clr_ch);
        flags[clr_ch] = 1'b0;
        clr_pend = 0;
      end else begin
        chk(!flag_clr, "R6 no stray strobe", flag_clr, 0);
      end
      if (prev_stall) chk(cell_valid, "R7 valid held in stall", cell_valid, 1);
      prev_stall = cell_valid && !cell_ready;
      if (cell_valid) begin
        logic [7:0] e;
        if (cnt == 0 && !open_cell) begin
          int c;
          c = pick_model();
          chk(c >= 0 && int'(mem_ch) == c, "R4 channel order", int'(mem_ch), c);
          cur_ch = (c < 0) ? 0 : c;
          cur_hdr = hdr_model(csi_b[cur_ch], exp_sc[cur_ch]);
          open_cell = 1;
        end
        e = (cnt == 0) ? cur_hdr : mem[cur_ch][cnt-1];
        chk(cell_sof == (cnt == 0), "R9 sof position", cell_sof, cnt == 0);
        if (cnt == 0) chk(cell_data == e, "R2 R5 header", cell_data, e);
        else          chk(cell_data == e, "R1 payload byte", cell_data, e);
        if (cell_ready) begin
          if (cnt == PB) begin
            cnt = 0;
            open_cell = 0;
            exp_sc[cur_ch] = exp_sc[cur_ch] + 3'd1;
            exp_ptr = (cur_ch + 1) % N_CH;
            clr_pend = 1;
            clr_ch = cur_ch;
          end else cnt++;
        end
      end
    end
  end

  task automatic wait_idle();
    do begin
      @(negedge clk); #2;
    end while (flags != '0 || open_cell || clr_pend || cnt != 0);
  endtask

  initial begin
    logic [7:0] h;
    void'($urandom(32'd4242));
    for (int c = 0; c < N_CH; c++)
      for (int i = 0; i < PB; i++) mem[c][i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk(!cell_valid, "R8 idle after reset", cell_valid, 0);
    chk(!flag_clr, "R8 no strobe after reset", flag_clr, 0);

    // R3: csi changes after selection do not reach the header
    force_stall = 1;
    csi_b[5] = 1'b1;
    flags = 8'b0010_0000;
    repeat (3) begin @(negedge clk); end
    #2;
    h = cell_data;
    chk(cell_valid && cell_sof && h == hdr_model(1'b1, 3'd0), "R3 R8 first header", h, hdr_model(1'b1, 3'd0));
    csi_b[5] = 1'b0;
    repeat (2) begin @(negedge clk); end
    #2;
    chk(cell_data == h, "R3 header kept", cell_data, h);
    force_stall = 0;
    wait_idle();

    // R4: all ready, order must run 6,7,0..5
    csi_b = 8'hA5;
    flags = 8'hFF;
    wait_idle();

    // R5: channel 2 alone nine times crosses the 7->0 wrap
    for (int n = 0; n < 9; n++) begin
      flags[2] = 1'b1;
      wait_idle();
    end

    // constrained random batches
    for (int b = 0; b < 40; b++) begin
      repeat ($urandom_range(0, 3)) begin @(negedge clk); end
      #2;
      csi_b = 8'($urandom);
      flags = 8'($urandom);
      if (flags == '0) flags = 8'h01;
      wait_idle();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule